// File: doc/BRIEF.md
# Streaming SPI Slave

This block is the device side of a four-wire serial link. It samples the serial data input and shifts a W-bit word into a parallel register. At the same time it shifts a user-supplied W-bit word out on the serial data output, most significant bit first. Clock polarity and phase are chosen at run time, so all four serial modes are covered. The serial clock, select and data input are brought into the single system clock through a two-flop synchroniser. Edges of the synchronised serial clock then drive a small state machine. Each serial half-period must therefore last at least four system clocks.

The user writes the next outgoing word into a holding register through a write-enable port. Each time the block copies that register into its shift register, it pulses a data-request strobe, asking for the following word. Words stream back to back for as long as select stays low and the master keeps clocking. If the user writes nothing, the previous word goes out again.

While the link is idle, the serial output is fed from a multiplexer that presents the most significant bit of the holding register. The multiplexer select is a flip-flop, so the output moves to the shift register only on the clock that first updates that register.

The state machine has three states:
- LNK_IDLE: select is high and the counters are cleared. It goes to LNK_ARMED when select is seen low.
- LNK_ARMED: select is low but the shift register has not yet been updated. It goes to LNK_STREAM on the first change edge, and back to LNK_IDLE if select rises.
- LNK_STREAM: the shift register drives the output. It goes back to LNK_IDLE when select rises.

Top module: `spi_stream_slave`

## Requirements
- R1: The idle level of the serial clock equals `cpol_i`, and the leading edge is the transition away from that level. With `cpha_i`=0 the input is sampled on leading edges and the output changes on trailing edges. With `cpha_i`=1 it is the other way round.
- R2: A word is W bits long and travels most significant bit first in both directions.
- R3: Until the first change edge after select falls, `miso_o` equals bit W-1 of the holding register, so the first bit is valid before any clock edge. After that edge, a registered select switches `miso_o` to the shift register.
- R4: One system clock after the W-th sample of a word, `rx_valid_o` is high for exactly one cycle, and `rx_data_o` then holds the word.
- R5: `tx_done_o` pulses in the same cycle as `rx_valid_o`.
- R6: While select stays low, successive words follow each other with no idle gap between them.
- R7: The holding register is copied into the shift register at these points. With `cpha_i`=1, on the first leading edge of each word. With `cpha_i`=0, on the first trailing edge of the transfer and on the last trailing edge of every word. `data_req_o` pulses one cycle after each copy, so a transfer of n words gives n requests with `cpha_i`=1 and n+1 with `cpha_i`=0.
- R8: If no word is written between two copies, the same word is transmitted again.
- R9: A write that lands on the same clock as a copy does not reach the word being copied. The new value goes out at the next copy.
- R10: Raising select clears the bit counters. A partial word produces no `rx_valid_o`, and the next select starts a fresh word.
- R11: After reset, `miso_o`, `rx_data_o`, `rx_valid_o`, `tx_done_o` and `data_req_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| sck_i | input | 1 | Serial clock from master |
| ssel_n_i | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| wr_en_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | W | Next word to transmit |
| data_req_o | output | 1 | One-cycle request for the next word |
| rx_data_o | output | W | Last received word |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_data_o` |
| tx_done_o | output | 1 | One-cycle strobe when a word has been fully sent |

## Verification
Two functions can fall in the same clock: a user write and a copy of the holding register into the shift register. To provoke this, the bench counts the synchroniser and edge-register stages after a leading edge in mode cpha=1, and drives the write strobe so that it is sampled on exactly the clock of the copy. The bench then expects that word to repeat the old holding value and the following word to carry the new one. Random transfers also mix prompt reloads with skipped reloads, which tests how the repeat rule interacts with the request strobe.

// File: rtl/spi_stream_pkg.sv
package spi_stream_pkg;
    typedef enum logic [1:0] {
        LNK_IDLE   = 2'b00,
        LNK_ARMED  = 2'b01,
        LNK_STREAM = 2'b10
    } lnk_state_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int           N       = 3,
    parameter int           STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [STAGES-1:0][N-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_edge_sel.sv
module spi_edge_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic cpol,
    input  logic cpha,
    output logic smp_ev,
    output logic chg_ev
);
    logic sck_d;
    logic rise, fall, lead, trail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    assign rise  = sck_s & ~sck_d;
    assign fall  = sck_d & ~sck_s;
    assign lead  = cpol ? fall : rise;
    assign trail = cpol ? rise : fall;

    assign smp_ev = cpha ? trail : lead;
    assign chg_ev = cpha ? lead  : trail;
endmodule

// File: rtl/spi_bit_fsm.sv
module spi_bit_fsm
    import spi_stream_pkg::*;
#(
    parameter int W  = 8,
    localparam int CW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_act,
    input  logic          smp_ev,
    input  logic          chg_ev,
    input  logic          cpha,
    output logic          take_bit,
    output logic          word_end,
    output logic          tx_load,
    output logic          tx_shift,
    output logic          use_sh,
    output lnk_state_t    st,
    output logic [CW-1:0] smp_idx
);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    lnk_state_t    state_q, state_d;
    logic          use_sh_q;
    logic [CW-1:0] smp_cnt, chg_cnt;
    logic          cnt_clr, pick_load, smp_last, chg_last;

    assign smp_last  = (smp_cnt == LAST);
    assign chg_last  = (chg_cnt == LAST);
    assign pick_load = cpha ? (chg_cnt == '0) : chg_last;

    // state register and registered output-mux select
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= LNK_IDLE;
            use_sh_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            use_sh_q <= (state_d == LNK_STREAM);
        end
    end

    // transitions
    always_comb begin
        unique case (state_q)
            LNK_IDLE:   state_d = sel_act ? LNK_ARMED : LNK_IDLE;
            LNK_ARMED:  state_d = !sel_act ? LNK_IDLE :
                                  (chg_ev ? LNK_STREAM : LNK_ARMED);
            LNK_STREAM: state_d = sel_act ? LNK_STREAM : LNK_IDLE;
            default:    state_d = LNK_IDLE;
        endcase
    end

    // outputs, every one assigned in every state
    always_comb begin
        unique case (state_q)
            LNK_IDLE: begin
                take_bit = 1'b0;
                word_end = 1'b0;
                tx_load  = 1'b0;
                tx_shift = 1'b0;
                cnt_clr  = 1'b1;
            end
            LNK_ARMED: begin
                take_bit = sel_act & smp_ev;
                word_end = sel_act & smp_ev & smp_last;
                tx_load  = sel_act & chg_ev & pick_load;
                tx_shift = sel_act & chg_ev & ~pick_load;
                cnt_clr  = ~sel_act;
            end
            LNK_STREAM: begin
                take_bit = sel_act & smp_ev;
                word_end = sel_act & smp_ev & smp_last;
                tx_load  = sel_act & chg_ev & pick_load;
                tx_shift = sel_act & chg_ev & ~pick_load;
                cnt_clr  = ~sel_act;
            end
            default: begin
                take_bit = 1'b0;
                word_end = 1'b0;
                tx_load  = 1'b0;
                tx_shift = 1'b0;
                cnt_clr  = 1'b1;
            end
        endcase
    end

    // bit-state counters, cycling 0..W-1 while the clock runs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_cnt <= '0;
            chg_cnt <= '0;
        end else if (cnt_clr) begin
            smp_cnt <= '0;
            chg_cnt <= '0;
        end else begin
            if (take_bit)            smp_cnt <= smp_last ? '0 : smp_cnt + 1'b1;
            if (tx_load | tx_shift)  chg_cnt <= chg_last ? '0 : chg_cnt + 1'b1;
        end
    end

    assign use_sh  = use_sh_q;
    assign st      = state_q;
    assign smp_idx = smp_cnt;
endmodule

// File: rtl/spi_stream_slave.sv
module spi_stream_slave
    import spi_stream_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cpol_i,
    input  logic         cpha_i,
    input  logic         sck_i,
    input  logic         ssel_n_i,
    input  logic         mosi_i,
    output logic         miso_o,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    output logic         data_req_o,
    output logic [W-1:0] rx_data_o,
    output logic         rx_valid_o,
    output logic         tx_done_o
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    logic          ssel_s, sck_s, mosi_s;
    logic          smp_ev, chg_ev;
    logic          take_bit, word_end, tx_load, tx_shift, use_sh;
    lnk_state_t    st;
    logic [CW-1:0] smp_idx;
    logic [W-1:0]  tx_buf, tx_sh, rx_sh, rx_next, sh_src;
    logic          req_q, valid_q, done_q;
    logic [W-1:0]  rx_q;

    spi_in_sync #(.N(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ssel_n_i, sck_i, mosi_i}),
        .q     ({ssel_s, sck_s, mosi_s})
    );

    spi_edge_sel u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_s  (sck_s),
        .cpol   (cpol_i),
        .cpha   (cpha_i),
        .smp_ev (smp_ev),
        .chg_ev (chg_ev)
    );

    spi_bit_fsm #(.W(W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_act  (~ssel_s),
        .smp_ev   (smp_ev),
        .chg_ev   (chg_ev),
        .cpha     (cpha_i),
        .take_bit (take_bit),
        .word_end (word_end),
        .tx_load  (tx_load),
        .tx_shift (tx_shift),
        .use_sh   (use_sh),
        .st       (st),
        .smp_idx  (smp_idx)
    );

    assign sh_src  = use_sh ? tx_sh : tx_buf;
    assign rx_next = (rx_sh << 1) | W'(mosi_s);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_buf  <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_q    <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            if (wr_en_i)       tx_buf <= wr_data_i;
            if (tx_load)       tx_sh  <= tx_buf;
            else if (tx_shift) tx_sh  <= sh_src << 1;
            if (take_bit)      rx_sh  <= rx_next;
            if (word_end)      rx_q   <= rx_next;
            valid_q <= word_end;
            done_q  <= word_end;
            req_q   <= tx_load | (tx_shift & ~use_sh);
        end
    end

    assign miso_o     = use_sh ? tx_sh[W-1] : tx_buf[W-1];
    assign rx_data_o  = rx_q;
    assign rx_valid_o = valid_q;
    assign tx_done_o  = done_q;
    assign data_req_o = req_q;
endmodule

// File: rtl/spi_stream_checks.sv
module spi_stream_checks
    import spi_stream_pkg::*;
#(
    parameter int W  = 8,
    localparam int CW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ssel_s,
    input  logic          chg_ev,
    input  logic          use_sh,
    input  logic          miso_o,
    input  logic          rx_valid_o,
    input  logic          data_req_o,
    input  logic [W-1:0]  tx_buf,
    input  lnk_state_t    st,
    input  logic [CW-1:0] smp_idx
);
    p_preload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LNK_IDLE) |-> (miso_o == tx_buf[W-1]));

    p_sel_after_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(use_sh) |-> $past(chg_ev));

    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_req_o |=> !data_req_o);

    p_abort_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ssel_s |=> (smp_idx == '0));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LNK_IDLE) |-> (!rx_valid_o && !data_req_o));
endmodule

bind spi_stream_slave spi_stream_checks #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ssel_s     (ssel_s),
    .chg_ev     (chg_ev),
    .use_sh     (use_sh),
    .miso_o     (miso_o),
    .rx_valid_o (rx_valid_o),
    .data_req_o (data_req_o),
    .tx_buf     (tx_buf),
    .st         (st),
    .smp_idx    (smp_idx)
);

// File: tb/sim_spi_stream_slave.sv
module sim_spi_stream_slave;
    localparam int W  = 8;
    localparam int HP = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpol = 1'b0, cpha = 1'b0, sck = 1'b0, ssel = 1'b1, mosi = 1'b0;
    logic miso, data_req, rx_valid, tx_done;
    logic [W-1:0] rx_data;
    logic pre_we = 1'b0, col_we = 1'b0, rsp_we = 1'b0;
    logic [W-1:0] pre_wd = '0, col_wd = '0, rsp_wd = '0;
    logic wr_en;
    logic [W-1:0] wr_data;

    assign wr_en   = pre_we | col_we | rsp_we;
    assign wr_data = pre_we ? pre_wd : (col_we ? col_wd : rsp_wd);

    always #10 clk = ~clk;

    spi_stream_slave #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cpol_i(cpol), .cpha_i(cpha),
        .sck_i(sck), .ssel_n_i(ssel), .mosi_i(mosi), .miso_o(miso),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .data_req_o(data_req),
        .rx_data_o(rx_data), .rx_valid_o(rx_valid), .tx_done_o(tx_done)
    );

    int n_checks = 0, n_fail = 0;
    int rx_cnt = 0, req_cnt = 0, rx_base = 0, req_base = 0, n_cur = 0;
    bit resp_en = 1'b0;
    logic [W-1:0] plan [8], send [8], expw [8], mrx [8], slv_rx [8];
    bit reload [8];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int c);
        repeat (c) @(negedge clk);
    endtask

    // user-side monitor and responder
    always @(negedge clk) begin
        rsp_we = 1'b0;
        if (rx_valid) begin
            slv_rx[rx_cnt % 8] = rx_data;
            rx_cnt++;
        end
        if (rx_valid !== tx_done) begin
            n_checks++; n_fail++;
            $display("FAIL R5 actual=%0h expected=%0h", tx_done, rx_valid);
        end
        if (data_req) begin
            if (resp_en && (req_cnt - req_base + 1 < n_cur) && reload[req_cnt - req_base + 1]) begin
                rsp_we = 1'b1;
                rsp_wd = plan[req_cnt - req_base + 1];
            end
            req_cnt++;
        end
    end

    function automatic void build_expect(input int n);
        expw[0] = plan[0];
        for (int i = 1; i < n; i++) expw[i] = reload[i] ? plan[i] : expw[i-1];
    endfunction

    task automatic xfer(input int n, input bit pol, input bit pha, input int col_k, input logic [W-1:0] col_v);
        cpol = pol; cpha = pha; sck = pol; ssel = 1'b1;
        wait_cyc(8);
        rx_base = rx_cnt; req_base = req_cnt; n_cur = n; resp_en = (col_k < 0);
        pre_wd = plan[0]; pre_we = 1'b1; wait_cyc(1); pre_we = 1'b0;
        ssel = 1'b0;
        mosi = pha ? 1'b0 : send[0][W-1];
        wait_cyc(2*HP);
        chk(miso === plan[0][W-1], "R3 preload", miso, plan[0][W-1]);
        for (int w = 0; w < n; w++) begin
            for (int b = W-1; b >= 0; b--) begin
                if (!pha) begin
                    mrx[w][b] = miso; sck = ~pol; wait_cyc(HP);
                    sck = pol;
                    if (b > 0) mosi = send[w][b-1];
                    else if (w + 1 < n) mosi = send[w+1][W-1];
                    wait_cyc(HP);
                end else begin
                    sck = ~pol; mosi = send[w][b];
                    if (w == col_k && b == W-1) begin
                        wait_cyc(2); col_we = 1'b1; col_wd = col_v;
                        wait_cyc(1); col_we = 1'b0; wait_cyc(HP-3);
                    end else wait_cyc(HP);
                    mrx[w][b] = miso; sck = pol; wait_cyc(HP);
                end
            end
        end
        ssel = 1'b1; mosi = 1'b0;
        wait_cyc(3*HP);
        for (int w = 0; w < n; w++) begin
            chk(mrx[w] == expw[w], "R1 R2 R6 R8 R9 tx word", mrx[w], expw[w]);
            chk(slv_rx[(rx_base + w) % 8] == send[w], "R2 R6 rx word", slv_rx[(rx_base + w) % 8], send[w]);
        end
        chk(rx_cnt - rx_base == n, "R4 valid count", rx_cnt - rx_base, n);
        chk(req_cnt - req_base == (pha ? n : n + 1), "R7 request count", req_cnt - req_base, pha ? n : n + 1);
    endtask

    task automatic abort_partial();
        cpol = 1'b0; cpha = 1'b0; sck = 1'b0; ssel = 1'b1;
        wait_cyc(8);
        rx_base = rx_cnt; resp_en = 1'b0;
        ssel = 1'b0; mosi = 1'b1; wait_cyc(2*HP);
        for (int b = 0; b < 3; b++) begin
            sck = 1'b1; wait_cyc(HP); sck = 1'b0; wait_cyc(HP);
        end
        ssel = 1'b1; wait_cyc(3*HP);
        chk(rx_cnt == rx_base, "R10 no strobe on partial word", rx_cnt - rx_base, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        wait_cyc(4);
        chk(miso === 1'b0 && rx_valid === 1'b0 && tx_done === 1'b0 && data_req === 1'b0,
            "R11 reset outputs", {miso, rx_valid, tx_done, data_req}, 0);
        rst_n = 1'b1;
        wait_cyc(2);
        chk(rx_data === '0, "R11 reset rx_data", rx_data, 0);

        // directed: every mode, full reload, three words
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 3; i++) begin
                plan[i] = W'(8'h5A + 8'(i * 37 + m)); send[i] = W'(8'hC3 ^ 8'(i * 11 + m)); reload[i] = 1'b1;
            end
            build_expect(3);
            xfer(3, m[1], m[0], -1, '0);
        end

        // directed: no reload at all, word must repeat (R8)
        for (int i = 0; i < 4; i++) begin
            plan[i] = W'(8'h81 + 8'(i)); send[i] = W'(8'h3C + 8'(i)); reload[i] = (i == 0);
        end
        build_expect(4);
        xfer(4, 1'b1, 1'b1, -1, '0);

        // directed: write lands on the copy clock (R9)
        plan[0] = 8'hA5; send[0] = 8'h11; send[1] = 8'h22; send[2] = 8'h33;
        expw[0] = 8'hA5; expw[1] = 8'hA5; expw[2] = 8'h6E;
        xfer(3, 1'b0, 1'b1, 1, 8'h6E);

        // directed: abort mid-word, then a clean transfer (R10)
        abort_partial();
        for (int i = 0; i < 2; i++) begin
            plan[i] = W'(8'hF0 - 8'(i)); send[i] = W'(8'h0F + 8'(i)); reload[i] = 1'b1;
        end
        build_expect(2);
        xfer(2, 1'b0, 1'b0, -1, '0);

        // constrained random
        for (int t = 0; t < 30; t++) begin
            int n;
            bit pol, pha;
            pol = 1'($urandom % 2); pha = 1'($urandom % 2);
            n = 1 + int'($urandom % 4);
            for (int i = 0; i < n; i++) begin
                plan[i] = W'($urandom); send[i] = W'($urandom);
                reload[i] = (i == 0) || ($urandom % 2 == 0);
            end
            build_expect(n);
            xfer(n, pol, pha, -1, '0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule